// File: doc/BRIEF.md
# Indexed Real-Time Clock Register Port

This block gives a processor byte-wide access to the register file of a real-time clock through two ports. The index port can only be written, and it picks one of fourteen registers. The data port reads or writes the register that the index points at. Indices 0 to 9 hold the clock bytes: seconds, minutes, hours, weekday, day of month, month and year, plus spare bytes. Index 10 is status A, index 11 is status B, and indices 12 and 13 are status C and D. The block does not advance the time of day. It supports only binary, 24-hour operation.

Status B carries a periodic-interrupt enable. While that bit is set, a built-in timer produces a one-cycle interrupt pulse every `INTERVAL` clock cycles and then starts its next period. If software writes an index out of range, or writes a value the block does not support to a status register, the block raises a one-cycle error pulse. The targeted state stays unchanged.

Each access lasts one cycle. `selData` low addresses the index port and `selData` high addresses the data port. Read data appears on `rdData` in the cycle after `rdEn` and holds until the next read.

Top module: `rtcRegPort`

## Requirements
- R1: A write to the index port with a value from 0x00 to 0x0D loads the index. A larger value leaves the index unchanged and raises the error pulse.
- R2: Indices 0 to 9 are plain bytes that reset to 0x00 and can be written and read back freely. A read of the index port returns 0x00.
- R3: Status A (index 10) resets to 0x26. A data write of exactly 0x26 is accepted. Any other value raises the error pulse and leaves status A unchanged.
- R4: Each read of status A first inverts bit 7 (update in progress), keeps the inverted value, and returns it. Two reads in a row therefore return values that differ in bit 7.
- R5: Status B (index 11) resets to 0x46. Bit 6 is the periodic enable, bit 3 is the square-wave enable, bit 2 selects binary mode and bit 1 selects 24-hour mode. A write is legal only when (value AND 0xB7) equals 0x06. An illegal write raises the error pulse and leaves status B unchanged.
- R6: Status C and D (indices 12 and 13) always read 0x00. Writes to them raise the error pulse and have no effect.
- R7: While status B bit 6 is set, `irqPulse` is high for one cycle every `INTERVAL` cycles. The first pulse comes `INTERVAL` cycles after reset is released, or after the write that sets the bit.
- R8: Clearing bit 6 stops the pulses and discards the partial period. Writing status B with bit 6 already set does not restart the current period.
- R9: `errPulse` is high for exactly the one cycle after an offending write. `rdData` is updated in the cycle after `rdEn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle |
| selData | input | 1 | 0 = index port, 1 = data port |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, registered |
| irqPulse | output | 1 | Periodic interrupt pulse |
| errPulse | output | 1 | Unsupported index or value was written |

## Verification
The assertions check four properties on every cycle:
- the index never leaves the range 0 to 13, and an out-of-range write leaves it unchanged;
- status B always holds a legal pattern;
- status A changes only on a legal write or a read of status A;
- interrupt pulses appear only while the enable was set and never on two cycles in a row.

Other behaviour can only be shown by the bench scenarios: the exact spacing of the pulses, the period that is not restarted when an enabled status B is rewritten, the bit 7 alternation across reads in a row, and the read-back values. A behavioural model in the bench tracks these and is compared on every clock.

// File: rtl/rtcPkg.sv
package rtcPkg;
  localparam int IDX_W       = 4;
  localparam int CLK_BYTES   = 10;
  localparam int IDX_MAX     = 13;
  localparam int IDX_STAT_A  = 10;
  localparam int IDX_STAT_B  = 11;
  localparam logic [7:0] STAT_A_INIT  = 8'h26;
  localparam logic [7:0] STAT_B_INIT  = 8'h46;
  localparam logic [7:0] STAT_B_FREE  = 8'h48; // periodic + square-wave enables
  localparam logic [7:0] STAT_B_FIXED = 8'h06; // binary + 24-hour
  localparam int UIP_BIT     = 7;
  localparam int PIE_BIT     = 6;

  typedef enum logic [2:0] {
    RD_NONE, RD_ZERO, RD_CLK, RD_STAT_A, RD_STAT_B
  } rdSel_t;

  typedef struct packed {
    logic   idxLoad;
    logic   clkWr;
    logic   statAWr;
    logic   statBWr;
    logic   badWrite;
    rdSel_t rdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/rtcCtl.sv
module rtcCtl
  import rtcPkg::*;
(
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             selData,
  input  logic [7:0]       wrData,
  input  logic [IDX_W-1:0] curIdx,
  output ctlStrobes_t      strobes
);
  logic idxOk, isClk, isA, isB, aOk, bOk, dataWr, idxWr;

  always_comb begin
    idxWr  = wrEn && !selData;
    dataWr = wrEn && selData;
    idxOk  = wrData <= 8'(IDX_MAX);
    isClk  = int'(curIdx) < CLK_BYTES;
    isA    = int'(curIdx) == IDX_STAT_A;
    isB    = int'(curIdx) == IDX_STAT_B;
    aOk    = wrData == STAT_A_INIT;
    bOk    = (wrData & ~STAT_B_FREE) == STAT_B_FIXED;

    strobes          = '0;
    strobes.idxLoad  = idxWr && idxOk;
    strobes.clkWr    = dataWr && isClk;
    strobes.statAWr  = dataWr && isA && aOk;
    strobes.statBWr  = dataWr && isB && bOk;
    strobes.badWrite = (idxWr && !idxOk)
                     || (dataWr && isA && !aOk)
                     || (dataWr && isB && !bOk)
                     || (dataWr && !isClk && !isA && !isB);
    if (!rdEn)        strobes.rdSel = RD_NONE;
    else if (!selData) strobes.rdSel = RD_ZERO;
    else if (isClk)   strobes.rdSel = RD_CLK;
    else if (isA)     strobes.rdSel = RD_STAT_A;
    else if (isB)     strobes.rdSel = RD_STAT_B;
    else              strobes.rdSel = RD_ZERO;
  end
endmodule

// File: rtl/rtcPeriodicTimer.sv
module rtcPeriodicTimer #(
  parameter int INTERVAL = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  output logic irqPulse
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      irqPulse <= 1'b0;
    end else if (!enable) begin
      cnt      <= '0;
      irqPulse <= 1'b0;
    end else if (cnt == LAST) begin
      cnt      <= '0;
      irqPulse <= 1'b1;
    end else begin
      cnt      <= cnt + 1'b1;
      irqPulse <= 1'b0;
    end
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(enable)); // R7

  generate
    if (INTERVAL > 1) begin : gSpacing
      AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
        irqPulse |=> !irqPulse); // R7
    end
  endgenerate
endmodule

// File: rtl/rtcDatapath.sv
module rtcDatapath
  import rtcPkg::*;
#(
  parameter int INTERVAL = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selData,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  ctlStrobes_t      strobes,
  output logic [IDX_W-1:0] curIdx,
  output logic [7:0]       rdData,
  output logic             irqPulse,
  output logic             errPulse
);
  logic [7:0] clkMem [CLK_BYTES];
  logic [7:0] statA, statB, statAFlip;

  assign statAFlip = statA ^ (8'h1 << UIP_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx   <= '0;
      statA    <= STAT_A_INIT;
      statB    <= STAT_B_INIT;
      rdData   <= '0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= strobes.badWrite;
      if (strobes.idxLoad) curIdx <= wrData[IDX_W-1:0];
      if (strobes.statBWr) statB <= wrData;
      if (strobes.statAWr) statA <= wrData;
      else if (strobes.rdSel == RD_STAT_A) statA <= statAFlip;
      case (strobes.rdSel)
        RD_ZERO:   rdData <= '0;
        RD_CLK:    rdData <= clkMem[curIdx];
        RD_STAT_A: rdData <= statAFlip;
        RD_STAT_B: rdData <= statB;
        default:   rdData <= rdData;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < CLK_BYTES; i++) begin : gClk
      always_ff @(posedge clk) begin
        if (!rstN) clkMem[i] <= '0;
        else if (strobes.clkWr && int'(curIdx) == i) clkMem[i] <= wrData;
      end
    end
  endgenerate

  rtcPeriodicTimer #(.INTERVAL(INTERVAL)) timer_i (
    .clk(clk), .rstN(rstN), .enable(statB[PIE_BIT]), .irqPulse(irqPulse)
  );

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(curIdx) <= IDX_MAX); // R1
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !selData && wrData > 8'(IDX_MAX)) |=> $stable(curIdx)); // R1
  AST_STAT_B_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (statB & ~STAT_B_FREE) == STAT_B_FIXED); // R5
  AST_STAT_A_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.statAWr && strobes.rdSel != RD_STAT_A) |=> $stable(statA)); // R3
endmodule

// File: rtl/rtcRegPort.sv
module rtcRegPort #(
  parameter int INTERVAL = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       selData,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irqPulse,
  output logic       errPulse
);
  import rtcPkg::*;

  ctlStrobes_t      strobes;
  logic [IDX_W-1:0] curIdx;

  rtcCtl ctl_i (
    .wrEn(wrEn), .rdEn(rdEn), .selData(selData), .wrData(wrData),
    .curIdx(curIdx), .strobes(strobes)
  );

  rtcDatapath #(.INTERVAL(INTERVAL)) dp_i (
    .clk(clk), .rstN(rstN), .selData(selData), .wrEn(wrEn), .wrData(wrData),
    .strobes(strobes), .curIdx(curIdx), .rdData(rdData),
    .irqPulse(irqPulse), .errPulse(errPulse)
  );
endmodule

// File: tb/rtcRegPort_tb_top.sv
module rtcRegPort_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IV = 20;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, selData = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic irqPulse, errPulse;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtcRegPort #(.INTERVAL(IV)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .selData(selData),
    .wrData(wrData), .rdData(rdData), .irqPulse(irqPulse), .errPulse(errPulse)
  );

  // behavioural reference model
  int mIdx, mA, mB, mRd, mCnt;
  int mMem[10];
  bit mIrq, mErr;

  always @(posedge clk) begin
    if (!rstN) begin
      mIdx = 0; mA = 'h26; mB = 'h46; mRd = 0; mCnt = 0; mIrq = 0; mErr = 0;
      foreach (mMem[i]) mMem[i] = 0;
    end else begin
      mIrq = 0;
      if (mB[6]) begin
        if (mCnt == IV - 1) begin mCnt = 0; mIrq = 1; end
        else mCnt++;
      end else mCnt = 0;
      mErr = 0;
      if (wrEn && !selData) begin
        if (wrData <= 13) mIdx = wrData; else mErr = 1;
      end else if (wrEn) begin
        if (mIdx < 10) mMem[mIdx] = wrData;
        else if (mIdx == 10) begin if (wrData == 8'h26) mA = wrData; else mErr = 1; end
        else if (mIdx == 11) begin if ((wrData & 8'hB7) == 8'h06) mB = wrData; else mErr = 1; end
        else mErr = 1;
      end
      if (rdEn) begin
        if (!selData) mRd = 0;
        else if (mIdx < 10) mRd = mMem[mIdx];
        else if (mIdx == 10) begin mA = mA ^ 'h80; mRd = mA; end
        else if (mIdx == 11) mRd = mB;
        else mRd = 0;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2 rdData vs model", rdData, mRd);
      check("R7 irqPulse vs model", irqPulse, mIrq);
      check("R9 errPulse vs model", errPulse, mErr);
    end
  end

  bit lastErr;
  task automatic busWr(bit sel, logic [7:0] v);
    wrEn = 1; selData = sel; wrData = v;
    @(negedge clk);
    wrEn = 0; lastErr = errPulse;
  endtask
  task automatic busRd(bit sel, output logic [7:0] v);
    rdEn = 1; selData = sel;
    @(negedge clk);
    rdEn = 0; v = rdData;
  endtask
  task automatic rdAt(logic [7:0] idx, string tag, logic [7:0] exp);
    logic [7:0] v;
    busWr(0, idx);
    busRd(1, v);
    check(tag, v, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1;
    check("reset errPulse R9", errPulse, 0);
    // R7: first pulse INTERVAL cycles after reset release
    n = 0;
    for (int i = 0; i < IV - 1; i++) begin @(negedge clk); n += irqPulse; end
    check("R7 no pulse before interval", n, 0);
    @(negedge clk);
    check("R7 first pulse", irqPulse, 1);
    // R2 reset values and read/write
    rdAt(3, "R2 reset byte", 8'h00);
    busWr(1, 8'hA5);
    busRd(1, v); check("R2 readback", v, 8'hA5);
    busWr(0, 9); busWr(1, 8'h3C);
    rdAt(9, "R2 index 9", 8'h3C);
    rdAt(3, "R2 index 3 kept", 8'hA5);
    busRd(0, v); check("R2 index port reads zero", v, 0);
    // R1 illegal index
    busWr(0, 8'h0E); check("R1 err on 0x0E", lastErr, 1);
    busRd(1, v); check("R1 index unchanged", v, 8'hA5);
    busWr(0, 8'hFF); check("R1 err on 0xFF", lastErr, 1);
    busWr(0, 8'h0D); check("R1 0x0D legal", lastErr, 0);
    // R6
    busRd(1, v); check("R6 status D zero", v, 0);
    busWr(1, 8'h55); check("R6 write D err", lastErr, 1);
    busRd(1, v); check("R6 status D still zero", v, 0);
    rdAt(12, "R6 status C zero", 0);
    busWr(1, 8'h01); check("R6 write C err", lastErr, 1);
    // R3 / R4
    rdAt(10, "R4 first read A", 8'hA6);
    busRd(1, v); check("R4 second read A", v, 8'h26);
    busRd(1, v2); check("R4 third read A", v2, 8'hA6);
    busWr(1, 8'h20); check("R3 illegal A err", lastErr, 1);
    busRd(1, v); check("R3 A unchanged", v, 8'h26);
    busWr(1, 8'h26); check("R3 legal A", lastErr, 0);
    busRd(1, v); check("R3 A after legal write", v, 8'hA6);
    // R5
    rdAt(11, "R5 reset B", 8'h46);
    busWr(1, 8'h07); check("R5 illegal B err", lastErr, 1);
    busRd(1, v); check("R5 B unchanged", v, 8'h46);
    busWr(1, 8'h4E); check("R5 legal B with SQW", lastErr, 0);
    busRd(1, v); check("R5 B readback", v, 8'h4E);
    // R8: rewrite with enable already set, mid-period; model confirms no restart
    repeat (7) @(negedge clk);
    busWr(1, 8'h46);
    repeat (2 * IV) @(negedge clk);
    // R8: disable stops pulses
    busWr(1, 8'h06); check("R8 disable legal", lastErr, 0);
    @(negedge clk);
    n = 0;
    for (int i = 0; i < 3 * IV; i++) begin @(negedge clk); n += irqPulse; end
    check("R8 no pulses while disabled", n, 0);
    // R7: re-enable, first pulse exactly INTERVAL cycles later
    busWr(1, 8'h46);
    n = 0;
    for (int i = 0; i < IV - 1; i++) begin @(negedge clk); n += irqPulse; end
    check("R7 none before interval after enable", n, 0);
    @(negedge clk);
    check("R7 pulse after enable", irqPulse, 1);
    @(negedge clk);
    check("R7 pulse is single cycle", irqPulse, 0);
    repeat (IV - 2) @(negedge clk);
    @(negedge clk);
    check("R7 second period pulse", irqPulse, 1);
    @(negedge clk);
    check("R9 err returns low", errPulse, 0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule